// File: doc/BRIEF.md
# Serial Memory Slave with Streaming Read

This block is the serial front end of a small nonvolatile-style memory. The memory is modelled as a register array. A host frames each transfer with a chip select and clocks in the bits on a serial clock: first a 4-bit instruction, then an address, then write data where the instruction needs it. Read data comes back on a serial output that is high-impedance whenever no read is being shifted out.

The instructions cover the following:
- a single read;
- a streaming read that walks successive addresses up to the top of the array;
- write and erase;
- setting and clearing a program enable;
- setting and clearing an access enable;
- loading a protection pointer that splits the array into a writable lower part and a read-only upper part.

An error flag, driven only while chip select is high, reports a rejected write, erase or pointer load.

Dropping chip select resets only the serial interface. The two enable flags, the pointer and an in-progress programming busy period are all kept. The serial clock is sampled by the system clock `clk`, so each serial clock half period must last at least two system clock cycles. The array organization is chosen by a parameter: 512 x 8 by default, or 256 x 16.

Top module: `ser_mem_slave`

## Requirements
- R1: While `cs` is low, `sdo_oe` and `err_oe` are low and any partly received instruction is abandoned. A write cut off by `cs` low leaves the array unchanged.
- R2: Bits on `sdi` are taken MSB first on rising `sclk` edges: a 4-bit opcode, then the address (9 bits for 512 x 8, 8 bits for 256 x 16), then any data. Read data goes out on `sdo` MSB first, one bit per falling `sclk` edge, starting with the first falling edge after the last address bit. Opcode 1 is a single read. After a single read the next instruction may follow without `cs` going low.
- R3: Opcode 3 writes the data word and opcode 4 erases the addressed word to all ones. Either one takes effect only when the program enable is set, no busy period is running and the address is below the pointer.
- R4: Opcode 2 is a streaming read. It outputs the word at the start address and then the word at each following address, one after another, for as long as `cs` stays high.
- R5: A streaming read stops after the word at the last address. From then on `sdo_oe` stays low until `cs` goes low.
- R6: Opcode 5 sets the program enable and opcode 6 clears it. Opcode 7 sets the access enable and opcode 8 clears it. Both flags survive `cs` low and are cleared only by their disable opcode or by `rst`.
- R7: Opcode 9 loads the pointer from a 10-bit operand (9 bits in the 256 x 16 organization). The load takes effect only while the access enable is set and no busy period runs. The pointer resets to the array depth.
- R8: A write or erase to an address at or above the pointer leaves the array unchanged and sets `err`. Addresses below the pointer are writable.
- R9: An accepted write or erase starts a busy period of `BUSY_CYC` clock cycles, which `cs` low does not shorten. A write, erase or pointer load that completes during this period is ignored and sets `err`.
- R10: `err_oe` follows `cs` with one cycle of delay. `err` is cleared whenever `cs` is low and stays set for the rest of a transfer once a rejection occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples `sclk` |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (0 means high-impedance) |
| err | output | 1 | Rejection flag for the current transfer |
| err_oe | output | 1 | Output enable for `err` |

## Verification
A table of writes to scattered addresses (lowest, middle, above 255), each read back with a single read, separates correct address and data bit order from shifted or reversed framing. A streaming read over three adjacent addresses shows that the address advances. A second streaming read started two words below the top shows that the stream stops and the output enable drops. Writes above and below a loaded pointer, and writes with each enable cleared, separate the individual guard terms. A write issued inside the busy period, and a write cut short by chip select, show that rejection and abandonment leave the array untouched while a second chip-select pulse does not end the busy period.

// File: rtl/ser_mem_pkg.sv
package ser_mem_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 4'd0,
    OP_READ  = 4'd1,
    OP_SEQ   = 4'd2,
    OP_WRITE = 4'd3,
    OP_ERASE = 4'd4,
    OP_PEN   = 4'd5,
    OP_PDIS  = 4'd6,
    OP_AEN   = 4'd7,
    OP_ADIS  = 4'd8,
    OP_PTR   = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ST_OP,
    ST_ADDR,
    ST_DATA,
    ST_OUT,
    ST_DONE
  } st_e;
endpackage

// File: rtl/sm_edge.sv
module sm_edge (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  output logic rise,
  output logic fall
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= sclk;
  end

  assign rise = sclk & ~sclk_q;
  assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/sm_array.sv
module sm_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sm_guard.sv
module sm_guard #(
  parameter int DEPTH    = 512,
  parameter int PTR_W    = 10,
  parameter int BUSY_CYC = 400
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_pen,
  input  logic             clr_pen,
  input  logic             set_aen,
  input  logic             clr_aen,
  input  logic             ptr_load,
  input  logic [PTR_W-1:0] ptr_val,
  input  logic             start_busy,
  output logic             prog_en,
  output logic             acc_en,
  output logic [PTR_W-1:0] ptr,
  output logic             busy
);
  localparam int BUSY_W = $clog2(BUSY_CYC + 1);
  logic [BUSY_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_en <= 1'b0;
      acc_en  <= 1'b0;
      ptr     <= PTR_W'(DEPTH);
      left    <= '0;
    end else begin
      if (set_pen)      prog_en <= 1'b1;
      else if (clr_pen) prog_en <= 1'b0;
      if (set_aen)      acc_en  <= 1'b1;
      else if (clr_aen) acc_en  <= 1'b0;
      if (ptr_load)     ptr     <= ptr_val;
      if (start_busy)   left    <= BUSY_W'(BUSY_CYC);
      else if (left != '0) left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
endmodule

// File: rtl/ser_mem_slave.sv
module ser_mem_slave
  import ser_mem_pkg::*;
#(
  parameter bit WIDE     = 1'b0,
  parameter int BUSY_CYC = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe,
  output logic err,
  output logic err_oe
);
  localparam int DATA_W = WIDE ? 16 : 8;
  localparam int DEPTH  = WIDE ? 256 : 512;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DATA_W + PTR_W + 1);
  localparam int BIT_W  = $clog2(DATA_W);

  logic rise, fall;
  st_e st;
  logic [CNT_W-1:0] cnt;
  logic [OP_W-1:0] op_sh;
  logic [PTR_W-1:0] sh_addr;
  logic [DATA_W-1:0] sh_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_word;
  logic prog_en, acc_en, busy;
  logic [PTR_W-1:0] ptr;

  logic [OP_W-1:0] op_full;
  logic [PTR_W-1:0] addr_full;
  logic [DATA_W-1:0] data_full;
  logic [CNT_W-1:0] addr_len;
  logic op_done, addr_done, data_done, out_done;
  logic wr_ok, er_ok, ptr_ok, reject;
  logic mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [BIT_W-1:0] bit_sel;

  sm_edge u_edge (.clk(clk), .rst(rst), .sclk(sclk), .rise(rise), .fall(fall));

  always_comb begin
    op_full   = {op_sh[OP_W-2:0], sdi};
    addr_full = {sh_addr[PTR_W-2:0], sdi};
    data_full = {sh_data[DATA_W-2:0], sdi};
    addr_len  = (op_sh == OP_PTR) ? CNT_W'(PTR_W) : CNT_W'(ADDR_W);
    op_done   = cs && rise && (st == ST_OP)   && (cnt == CNT_W'(OP_W - 1));
    addr_done = cs && rise && (st == ST_ADDR) && (cnt == addr_len - 1'b1);
    data_done = cs && rise && (st == ST_DATA) && (cnt == CNT_W'(DATA_W - 1));
    out_done  = cs && rise && (st == ST_OUT)  && (cnt == CNT_W'(DATA_W - 1));
    wr_ok  = prog_en && !busy && ({1'b0, sh_addr[ADDR_W-1:0]} < ptr);
    er_ok  = prog_en && !busy && ({1'b0, addr_full[ADDR_W-1:0]} < ptr);
    ptr_ok = acc_en && !busy;
    mem_we    = (data_done && op_sh == OP_WRITE && wr_ok) ||
                (addr_done && op_sh == OP_ERASE && er_ok);
    mem_waddr = (op_sh == OP_WRITE) ? sh_addr[ADDR_W-1:0] : addr_full[ADDR_W-1:0];
    mem_wdata = (op_sh == OP_WRITE) ? data_full : '1;
    reject    = (data_done && op_sh == OP_WRITE && !wr_ok) ||
                (addr_done && op_sh == OP_ERASE && !er_ok) ||
                (addr_done && op_sh == OP_PTR   && !ptr_ok);
    bit_sel   = BIT_W'(DATA_W - 1) - BIT_W'(cnt);
  end

  sm_guard #(.DEPTH(DEPTH), .PTR_W(PTR_W), .BUSY_CYC(BUSY_CYC)) u_guard (
    .clk(clk), .rst(rst),
    .set_pen(op_done && op_full == OP_PEN),
    .clr_pen(op_done && op_full == OP_PDIS),
    .set_aen(op_done && op_full == OP_AEN),
    .clr_aen(op_done && op_full == OP_ADIS),
    .ptr_load(addr_done && op_sh == OP_PTR && ptr_ok),
    .ptr_val(addr_full),
    .start_busy(mem_we),
    .prog_en(prog_en), .acc_en(acc_en), .ptr(ptr), .busy(busy)
  );

  sm_array #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) err_oe <= 1'b0;
    else     err_oe <= cs;
  end

  always_ff @(posedge clk) begin
    if (rst || !cs) begin
      st      <= ST_OP;
      cnt     <= '0;
      op_sh   <= '0;
      sh_addr <= '0;
      sh_data <= '0;
      sdo_oe  <= 1'b0;
      err     <= 1'b0;
      if (rst) begin
        rd_addr <= '0;
        sdo     <= 1'b0;
      end
    end else begin
      if (rise) begin
        cnt <= cnt + 1'b1;
        case (st)
          ST_OP: begin
            op_sh <= op_full;
            if (op_done) begin
              cnt     <= '0;
              sh_addr <= '0;
              case (op_full)
                OP_READ, OP_SEQ, OP_WRITE, OP_ERASE, OP_PTR: st <= ST_ADDR;
                OP_PEN, OP_PDIS, OP_AEN, OP_ADIS:            st <= ST_OP;
                default:                                     st <= ST_DONE;
              endcase
            end
          end
          ST_ADDR: begin
            sh_addr <= addr_full;
            if (addr_done) begin
              cnt <= '0;
              case (op_sh)
                OP_READ, OP_SEQ: begin
                  rd_addr <= addr_full[ADDR_W-1:0];
                  st      <= ST_OUT;
                end
                OP_WRITE: st <= ST_DATA;
                default:  st <= ST_OP;
              endcase
            end
          end
          ST_DATA: begin
            sh_data <= data_full;
            if (data_done) begin
              cnt <= '0;
              st  <= ST_OP;
            end
          end
          ST_OUT: begin
            if (out_done) begin
              cnt <= '0;
              if (op_sh != OP_SEQ) begin
                st     <= ST_OP;
                sdo_oe <= 1'b0;
              end else if (rd_addr == ADDR_W'(DEPTH - 1)) begin
                st     <= ST_DONE;
                sdo_oe <= 1'b0;
              end else begin
                rd_addr <= rd_addr + 1'b1;
              end
            end
          end
          default: cnt <= cnt;
        endcase
      end else if (fall && st == ST_OUT) begin
        sdo    <= rd_word[bit_sel];
        sdo_oe <= 1'b1;
      end
      if (reject) err <= 1'b1;
    end
  end
endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              sdo_oe,
  input logic              err_oe,
  input logic              prog_en,
  input logic              acc_en,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_waddr,
  input logic [ADDR_W:0]   ptr
);
  assert_hiz_R1: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (!sdo_oe && !err_oe));

  assert_write_needs_enable_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> prog_en);

  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !cs |=> ($stable(prog_en) && $stable(acc_en)));

  assert_below_pointer_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ({1'b0, mem_waddr} < ptr));

  assert_busy_after_write_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> busy);

  assert_err_enable_lag_R10: assert property (@(posedge clk) disable iff (rst)
    err_oe |-> $past(cs));
endmodule

bind ser_mem_slave sm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .sdo_oe(sdo_oe), .err_oe(err_oe),
  .prog_en(prog_en), .acc_en(acc_en), .busy(busy),
  .mem_we(mem_we), .mem_waddr(mem_waddr), .ptr(ptr)
);

// File: tb/ser_mem_slave_test.sv
module ser_mem_slave_test;
  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe, err, err_oe;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ser_mem_slave uut (.clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .sdi(sdi),
                     .sdo(sdo), .sdo_oe(sdo_oe), .err(err), .err_oe(err_oe));

  // {address[8:0], data[7:0]} written and then read back
  localparam logic [16:0] VEC [6] = '{
    {9'd10, 8'hA5}, {9'd11, 8'h3C}, {9'd12, 8'h0F},
    {9'd0, 8'h81}, {9'd255, 8'h7E}, {9'd300, 8'hC3}};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bitx(input logic din, output logic dout, output logic doe);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    dout = sdo; doe = sdo_oe;
    sdi = din; sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic d, o;
    for (int i = n - 1; i >= 0; i--) bitx(v[i], d, o);
  endtask

  task automatic get(input int n, output logic [31:0] v, output logic alloe);
    logic d, o;
    v = '0; alloe = 1'b1;
    for (int i = 0; i < n; i++) begin
      bitx(1'b0, d, o);
      v = {v[30:0], d};
      alloe = alloe & o;
    end
  endtask

  task automatic begin_tx;
    sclk = 1'b0; cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic end_tx;
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    cs = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic simple(input logic [3:0] op);
    begin_tx; send(op, 4); end_tx;
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d, output logic e);
    begin_tx; send(3, 4); send(a, 9); send(d, 8); e = err; end_tx;
  endtask

  task automatic er(input logic [8:0] a, output logic e);
    begin_tx; send(4, 4); send(a, 9); e = err; end_tx;
  endtask

  task automatic setptr(input logic [9:0] p, output logic e);
    begin_tx; send(9, 4); send(p, 10); e = err; end_tx;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] v, output logic oe);
    begin_tx; send(1, 4); send(a, 9); get(8, v, oe); end_tx;
  endtask

  task automatic wait_busy;
    repeat (420) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic e, oe, d, o;
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset sdo_oe", sdo_oe, 0);
    check("R1 reset err_oe", err_oe, 0);

    wr(9'd20, 8'h11, e);
    check("R3 write without program enable", e, 1);
    simple(4'd5);
    foreach (VEC[i]) begin
      wr(VEC[i][16:8], VEC[i][7:0], e);
      check("R3 write accepted", e, 0);
      wait_busy;
      rd(VEC[i][16:8], v, oe);
      check("R2 single read data", v, VEC[i][7:0]);
      check("R2 single read oe", oe, 1);
    end

    // R2: a single read followed by another instruction, no cs pulse
    begin_tx; send(1, 4); send(9'd0, 9); get(8, v, oe);
    send(1, 4); send(9'd255, 9); get(8, v, oe); end_tx;
    check("R2 back-to-back read", v, 8'h7E);

    begin_tx; send(2, 4); send(9'd10, 9); get(24, v, oe); end_tx;
    check("R4 streaming read", v, 32'h00A53C0F);
    check("R4 streaming oe", oe, 1);

    simple(4'd6);
    wr(9'd10, 8'h00, e);
    check("R6 disabled write rejected", e, 1);
    rd(9'd10, v, oe);
    check("R6 disabled write no effect", v, 8'hA5);
    simple(4'd5);

    er(9'd11, e);
    check("R3 erase accepted", e, 0);
    wait_busy;
    rd(9'd11, v, oe);
    check("R3 erase value", v, 8'hFF);

    wr(9'd510, 8'h5A, e); wait_busy;
    wr(9'd511, 8'hA6, e); wait_busy;
    begin_tx; send(2, 4); send(9'd510, 9); get(16, v, oe);
    check("R5 stream at top data", v, 16'h5AA6);
    bitx(1'b0, d, o);
    check("R5 stream stops oe", o, 0);
    end_tx;

    setptr(10'd100, e);
    check("R7 pointer load without access enable", e, 1);
    wr(9'd300, 8'h00, e);
    check("R7 pointer unchanged", e, 0);
    wait_busy;
    wr(9'd300, 8'hC3, e); wait_busy;
    simple(4'd7);
    setptr(10'd100, e);
    check("R7 pointer load accepted", e, 0);
    wr(9'd300, 8'h00, e);
    check("R8 protected write error", e, 1);
    rd(9'd300, v, oe);
    check("R8 protected write no effect", v, 8'hC3);
    wr(9'd50, 8'h44, e);
    check("R8 write below pointer", e, 0);
    wait_busy;
    rd(9'd50, v, oe);
    check("R8 below pointer data", v, 8'h44);
    simple(4'd8);
    setptr(10'd512, e);
    check("R7 pointer load after access disable", e, 1);
    simple(4'd7);
    setptr(10'd512, e);
    check("R7 pointer restore", e, 0);

    wr(9'd60, 8'h12, e);
    check("R9 first write", e, 0);
    wr(9'd12, 8'hEE, e);
    check("R9 write during busy rejected", e, 1);
    rd(9'd12, v, oe);
    check("R9 busy write no effect", v, 8'h0F);
    wait_busy;
    wr(9'd12, 8'hEE, e);
    check("R9 write after busy", e, 0);
    wait_busy;

    begin_tx; send(3, 4); send(9'd10, 9); send(4'hF, 4);
    sclk = 1'b0; repeat (4) @(negedge clk);
    cs = 1'b0; repeat (4) @(negedge clk);
    check("R10 err_oe low with cs low", err_oe, 0);
    rd(9'd10, v, oe);
    check("R1 abandoned write", v, 8'hA5);

    begin_tx;
    check("R10 err clear at transfer start", {err_oe, err}, 2'b10);
    end_tx;

    rst = 1'b1; repeat (3) @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    wr(9'd10, 8'h00, e);
    check("R6 reset clears program enable", e, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule